// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller

This block is the test-port controller for a scan-testable bus device. It has four test pins: test clock, mode select, serial data in and serial data out. It runs the sixteen-state test access state machine, holds an instruction register and decodes it, and owns three data registers: a one-bit bypass, a 32-bit identification word and a small boundary-control register. The boundary-scan register is outside this block. It is reached through a serial port, with capture, shift and update strobes, a serial input and a serial return.

The active instruction chooses which data register sits between the serial input and output. It also drives mode outputs for the rest of the device:

- test mode, which takes the bus boundary away from normal operation;
- clamp;
- high-impedance;
- sample;
- self-test.

Normal-mode instructions leave test mode low, so scanning does not disturb the functional path. Opcodes are 8 bits wide and carry even parity. Any opcode with odd parity, and any even-parity opcode not in the instruction set, acts as BYPASS.

Top module: `scan_tap_ctrl`

## Requirements
- R1: Five consecutive rising test-clock edges with mode-select high put the state machine in Test-Logic-Reset from any state. Asserting `trst_n` low forces Test-Logic-Reset immediately. In that state all mode outputs are low.
- R2: Entering Test-Logic-Reset makes IDCODE the active instruction. The first data scan after reset shifts out the identification word (default 32'h1A5C_E0F1), least significant bit first. All mode outputs are low after reset.
- R3: Capture-IR loads the pattern 8'h01 into the instruction shift register, so the first 8 bits shifted out of every instruction scan are 1, then seven 0s.
- R4: `tdo_en` is high only while the state machine is in Shift-IR or Shift-DR. `tdo` and `tdo_en` change only on the falling edge of the test clock.
- R5: Each opcode selects one data register. EXTEST 8'h00, SAMPLE 8'h81, INTEST 8'h03 and SELFTEST 8'h0A select the boundary-scan port. IDCODE 8'h05 selects the identification register. BCRSCAN 8'h0C selects the boundary-control register. BYPASS 8'hFF, CLAMP 8'h06 and HIGHZ 8'h09 select bypass.
- R6: An opcode with an odd number of ones (for example 8'h01 or 8'h07), or an even-parity opcode not listed in R5 (for example 8'h11), behaves exactly as BYPASS.
- R7: The bypass register captures 0 in Capture-DR. When it is shifted, the serial output is the serial input delayed by one bit.
- R8: `test_mode` is high for EXTEST, INTEST, CLAMP, HIGHZ and SELFTEST. It is low for SAMPLE, IDCODE, BCRSCAN and BYPASS. Each of `clamp_en`, `highz_en`, `sample_en` and `self_test_en` is high only for its own instruction.
- R9: A newly shifted opcode takes effect only after Update-IR. While the opcode is being shifted and in Exit1-IR, the mode outputs keep their previous values.
- R10: The boundary-control register captures its current value in Capture-DR. `bcr_q` takes the shifted value only at Update-DR, and only while BCRSCAN is active. Scans through any other register leave `bcr_q` unchanged.
- R11: `bsr_capture`, `bsr_shift` and `bsr_update` pulse in Capture-DR, Shift-DR and Update-DR respectively, and only when a boundary-scan instruction is active. The serial output then follows `bsr_so`.
- R12: At most one of clamp, high-impedance, sample and self-test is high at a time. Clamp, high-impedance and self-test each imply `test_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdo_en | output | 1 | High when `tdo` is actively driven |
| bsr_capture | output | 1 | Boundary-scan port: capture strobe |
| bsr_shift | output | 1 | Boundary-scan port: shift strobe |
| bsr_update | output | 1 | Boundary-scan port: update strobe |
| bsr_si | output | 1 | Boundary-scan port: serial data toward the chain |
| bsr_so | input | 1 | Boundary-scan port: serial return from the chain |
| test_mode | output | 1 | Boundary is under test control |
| clamp_en | output | 1 | Outputs held at their boundary values |
| highz_en | output | 1 | Outputs released to high impedance |
| sample_en | output | 1 | Non-intrusive sampling active |
| self_test_en | output | 1 | Boundary-cell self-test active |
| bcr_q | output | BCR_W | Boundary-control register contents |

## Verification
The bench builds the block with its defaults: an identification register present (`HAS_ID` = 1), a 3-bit boundary-control register and the default identification word. This makes the reset-to-IDCODE path and the full 32-bit identification scan reachable. Every opcode in the table, along with odd-parity and unlisted opcodes, is driven through a full instruction scan and a data scan. Each check looks at the mode outputs, at which register answers on the serial output, and at the boundary-scan strobes. Directed cases cover reset by mode-select alone, asynchronous reset, and retention of the boundary-control value across scans of other registers.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BCR, DR_BSR} dr_sel_e;

  typedef struct packed {
    logic    test_mode;
    logic    clamp;
    logic    highz;
    logic    sample;
    logic    self_test;
    dr_sel_e sel;
  } ir_dec_t;

  localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h81;
  localparam logic [IR_W-1:0] OP_INTEST   = 8'h03;
  localparam logic [IR_W-1:0] OP_IDCODE   = 8'h05;
  localparam logic [IR_W-1:0] OP_CLAMP    = 8'h06;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 8'h09;
  localparam logic [IR_W-1:0] OP_SELFTEST = 8'h0A;
  localparam logic [IR_W-1:0] OP_BCRSCAN  = 8'h0C;
  localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;
  localparam logic [IR_W-1:0] IR_CAPTURE  = {{(IR_W-2){1'b0}}, 2'b01};
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
#(
  parameter bit HAS_ID = 1'b1
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_sr,
  output ir_dec_t         dec
);
  localparam logic [IR_W-1:0] RST_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;

  logic [IR_W-1:0] ir_act;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr  <= IR_CAPTURE;
      ir_act <= RST_OP;
    end else begin
      if (state == ST_CAP_IR)      ir_sr <= IR_CAPTURE;
      else if (state == ST_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (state == ST_TLR)         ir_act <= RST_OP;
      else if (state == ST_UPD_IR) ir_act <= ir_sr;
    end
  end

  always_comb begin
    dec     = '0;
    dec.sel = DR_BYP;
    if (!(^ir_act)) begin
      case (ir_act)
        OP_EXTEST:   begin dec.test_mode = 1'b1; dec.sel = DR_BSR; end
        OP_INTEST:   begin dec.test_mode = 1'b1; dec.sel = DR_BSR; end
        OP_SAMPLE:   begin dec.sample = 1'b1; dec.sel = DR_BSR; end
        OP_SELFTEST: begin dec.test_mode = 1'b1; dec.self_test = 1'b1; dec.sel = DR_BSR; end
        OP_CLAMP:    begin dec.test_mode = 1'b1; dec.clamp = 1'b1; end
        OP_HIGHZ:    begin dec.test_mode = 1'b1; dec.highz = 1'b1; end
        OP_IDCODE:   dec.sel = HAS_ID ? DR_ID : DR_BYP;
        OP_BCRSCAN:  dec.sel = DR_BCR;
        default:     dec.sel = DR_BYP;
      endcase
    end
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter bit          HAS_ID     = 1'b1,
  parameter logic [31:0] IDCODE_VAL = 32'h1A5C_E0F1,
  parameter int          BCR_W      = 3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  tap_state_e       state,
  input  dr_sel_e          sel,
  input  logic             bsr_so,
  output logic             dr_out,
  output logic [BCR_W-1:0] bcr_q
);
  logic             byp;
  logic             id_out;
  logic [BCR_W-1:0] bcr_sr;

  wire cap = (state == ST_CAP_DR);
  wire shf = (state == ST_SHF_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) byp <= 1'b0;
    else if (sel == DR_BYP) begin
      if (cap)      byp <= 1'b0;
      else if (shf) byp <= tdi;
    end
  end

  generate
    if (HAS_ID) begin : g_id
      logic [31:0] id_sr;
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) id_sr <= IDCODE_VAL;
        else if (sel == DR_ID) begin
          if (cap)      id_sr <= IDCODE_VAL;
          else if (shf) id_sr <= {tdi, id_sr[31:1]};
        end
      end
      assign id_out = id_sr[0];
    end else begin : g_no_id
      assign id_out = 1'b0;
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      bcr_sr <= '0;
      bcr_q  <= '0;
    end else if (state == ST_TLR) begin
      bcr_q <= '0;
    end else if (sel == DR_BCR) begin
      if (cap)                         bcr_sr <= bcr_q;
      else if (shf)                    bcr_sr <= {tdi, bcr_sr[BCR_W-1:1]};
      else if (state == ST_UPD_DR)     bcr_q  <= bcr_sr;
    end
  end

  always_comb begin
    unique case (sel)
      DR_ID:   dr_out = id_out;
      DR_BCR:  dr_out = bcr_sr[0];
      DR_BSR:  dr_out = bsr_so;
      default: dr_out = byp;
    endcase
  end
endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter bit          HAS_ID     = 1'b1,
  parameter logic [31:0] IDCODE_VAL = 32'h1A5C_E0F1,
  parameter int          BCR_W      = 3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  output logic             bsr_capture,
  output logic             bsr_shift,
  output logic             bsr_update,
  output logic             bsr_si,
  input  logic             bsr_so,
  output logic             test_mode,
  output logic             clamp_en,
  output logic             highz_en,
  output logic             sample_en,
  output logic             self_test_en,
  output logic [BCR_W-1:0] bcr_q
);
  tap_state_e      state;
  ir_dec_t         dec;
  logic [IR_W-1:0] ir_sr;
  logic            dr_out;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir #(.HAS_ID(HAS_ID)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .ir_sr(ir_sr), .dec(dec)
  );

  tap_dr #(.HAS_ID(HAS_ID), .IDCODE_VAL(IDCODE_VAL), .BCR_W(BCR_W)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .sel(dec.sel),
    .bsr_so(bsr_so), .dr_out(dr_out), .bcr_q(bcr_q)
  );

  wire live   = (state != ST_TLR);
  wire bsr_on = (dec.sel == DR_BSR);

  assign test_mode    = live & dec.test_mode;
  assign clamp_en     = live & dec.clamp;
  assign highz_en     = live & dec.highz;
  assign sample_en    = live & dec.sample;
  assign self_test_en = live & dec.self_test;

  assign bsr_capture = bsr_on & (state == ST_CAP_DR);
  assign bsr_shift   = bsr_on & (state == ST_SHF_DR);
  assign bsr_update  = bsr_on & (state == ST_UPD_DR);
  assign bsr_si      = tdi;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
      if (state == ST_SHF_IR)      tdo <= ir_sr[0];
      else if (state == ST_SHF_DR) tdo <= dr_out;
    end
  end
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_sr,
  input logic            tdo_en,
  input logic            test_mode,
  input logic            clamp_en,
  input logic            highz_en,
  input logic            sample_en,
  input logic            self_test_en
);
  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              hi_cnt <= '0;
    else if (!tms)            hi_cnt <= '0;
    else if (hi_cnt != 3'd5)  hi_cnt <= hi_cnt + 3'd1;
  end

  AST_TLR_AFTER_FIVE: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_cnt == 3'd5) |-> (state == ST_TLR)); // R1

  AST_TLR_MODES_OFF: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |-> !(test_mode | clamp_en | highz_en | sample_en | self_test_en)); // R1

  AST_CAPTURE_IR_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE)); // R3

  AST_TDO_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == ST_SHF_IR || state == ST_SHF_DR)); // R4

  AST_MODE_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(test_mode) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR || state == ST_TLR)); // R9

  AST_MODES_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({clamp_en, highz_en, sample_en, self_test_en})); // R12

  AST_FORCE_IMPLIES_TEST: assert property (@(posedge tck) disable iff (!trst_n)
    (clamp_en | highz_en | self_test_en) |-> test_mode); // R12
endmodule

bind scan_tap_ctrl scan_tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir_sr(ir_sr),
  .tdo_en(tdo_en), .test_mode(test_mode), .clamp_en(clamp_en), .highz_en(highz_en),
  .sample_en(sample_en), .self_test_en(self_test_en)
);

// File: tb/scan_tap_ctrl_tb.sv
`timescale 1ns/1ps
module scan_tap_ctrl_tb;
  localparam logic [31:0] IDV = 32'h1A5C_E0F1;
  localparam int          BW  = 3;
  localparam logic [7:0]  PAT = 8'hA5;

  // {opcode, test_mode, clamp, highz, sample, self_test, sel(0 byp,1 id,2 bcr,3 bsr)}
  localparam int NV = 12;
  localparam logic [14:0] VEC [NV] = '{
    {8'h00, 5'b10000, 2'd3}, {8'h81, 5'b00010, 2'd3}, {8'h03, 5'b10000, 2'd3},
    {8'h05, 5'b00000, 2'd1}, {8'h06, 5'b11000, 2'd0}, {8'h09, 5'b10100, 2'd0},
    {8'h0A, 5'b10001, 2'd3}, {8'h0C, 5'b00000, 2'd2}, {8'hFF, 5'b00000, 2'd0},
    {8'h01, 5'b00000, 2'd0}, {8'h07, 5'b00000, 2'd0}, {8'h11, 5'b00000, 2'd0}
  };

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_so = 1'b1;
  logic tdo, tdo_en, bsr_capture, bsr_shift, bsr_update, bsr_si;
  logic test_mode, clamp_en, highz_en, sample_en, self_test_en;
  logic [BW-1:0] bcr_q;

  int errs = 0, checks = 0;
  logic en_seen, bsrs_seen;
  logic [BW-1:0] bcr_exp = '0;

  always #2.5 tck = ~tck;

  scan_tap_ctrl u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .bsr_si(bsr_si), .bsr_so(bsr_so), .test_mode(test_mode), .clamp_en(clamp_en),
    .highz_en(highz_en), .sample_en(sample_en), .self_test_en(self_test_en), .bcr_q(bcr_q)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; en_seen = tdo_en; bsrs_seen = bsrs_seen | bsr_shift;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic nav(input logic m);
    logic o;
    step(m, 1'b0, o);
  endtask

  task automatic shift_bits(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = '0;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
  endtask

  task automatic to_shift_dr(); nav(1); nav(0); nav(0); endtask
  task automatic to_shift_ir(); nav(1); nav(1); nav(0); nav(0); endtask
  task automatic finish_scan(); nav(1); nav(0); endtask

  function automatic logic [4:0] modes();
    return {test_mode, clamp_en, highz_en, sample_en, self_test_en};
  endfunction

  task automatic load_ir(input logic [7:0] op);
    logic [31:0] o;
    to_shift_ir();
    shift_bits(8, {24'h0, op}, o);
    finish_scan();
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] o;
    logic [4:0]  prev;
    bsrs_seen = 1'b0;
    repeat (3) @(posedge tck);
    #1;
    check({31'h0, tdo_en}, 32'h0, "R4 reset tdo_en");
    check({27'h0, modes()}, 32'h0, "R2 reset modes");
    @(negedge tck); trst_n = 1'b1;
    nav(0);
    to_shift_dr();
    shift_bits(32, 32'h0, o);
    check(o, IDV, "R2 idcode after reset");
    check({31'h0, en_seen}, 32'h1, "R4 tdo_en in shift");
    finish_scan();
    nav(0);
    check({31'h0, en_seen}, 32'h0, "R4 tdo_en idle");

    // table of opcodes
    prev = 5'b0;
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  op;
      logic [4:0]  em;
      logic [1:0]  sel;
      logic [31:0] exp;
      op = VEC[v][14:7]; em = VEC[v][6:2]; sel = VEC[v][1:0];
      to_shift_ir();
      shift_bits(8, {24'h0, op}, o);
      check(o, 32'h01, "R3 capture-ir pattern");
      check({27'h0, modes()}, {27'h0, prev}, "R9 modes held before update");
      finish_scan();
      check({27'h0, modes()}, {27'h0, em}, (v >= 9) ? "R6 bad opcode modes" : "R8 modes");
      prev = em;
      bsrs_seen = 1'b0;
      to_shift_dr();
      shift_bits(8, {24'h0, PAT}, o);
      finish_scan();
      check({31'h0, bsrs_seen}, {31'h0, sel == 2'd3}, "R11 bsr shift strobe");
      case (sel)
        2'd0: check(o, {24'h0, PAT[6:0], 1'b0}, (v >= 9) ? "R6 bypass path" : "R7 bypass delay");
        2'd1: check(o, {24'h0, IDV[7:0]}, "R5 id select");
        2'd2: begin
          check({29'h0, o[BW-1:0]}, {29'h0, bcr_exp}, "R10 bcr capture");
          bcr_exp = PAT[7:5];
          check({29'h0, bcr_q}, {29'h0, bcr_exp}, "R10 bcr update");
        end
        default: check(o, 32'hFF, "R11 bsr serial return");
      endcase
    end

    // boundary-control value kept across other scans
    check({29'h0, bcr_q}, {29'h0, bcr_exp}, "R10 bcr retained");
    load_ir(8'h0C);
    to_shift_dr();
    shift_bits(BW, 32'h2, o);
    finish_scan();
    check({29'h0, o[BW-1:0]}, {29'h0, bcr_exp}, "R10 bcr capture of held value");
    check({29'h0, bcr_q}, 32'h2, "R10 bcr new value");

    // reset by mode-select alone
    load_ir(8'h00);
    check({31'h0, test_mode}, 32'h1, "R8 extest test mode");
    to_shift_dr();
    repeat (5) nav(1);
    check({27'h0, modes()}, 32'h0, "R1 five tms reset");
    nav(0);
    to_shift_dr();
    shift_bits(32, 32'h0, o);
    finish_scan();
    check(o, IDV, "R1 idcode after tms reset");

    // asynchronous reset
    load_ir(8'h06);
    check({27'h0, modes()}, 32'h18, "R8 clamp modes");
    @(negedge tck); #1 trst_n = 1'b0;
    #1;
    check({27'h0, modes()}, 32'h0, "R1 async reset modes");
    @(negedge tck); trst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule